// File: doc/BRIEF.md
# Clocked Synchronous Byte Serial Port

This block is a byte-wide serial link with a six-register byte bus. Two nodes are wired back to back so that two processors can pass bytes to each other. The sending node takes its clock from a prescaled baud generator and drives that clock on the serial clock pin. The receiving node takes the clock from its peer and samples data on each rising edge. Software polls the status flags. There are no interrupt or DMA paths.

Each byte goes out least significant bit first. Data changes on the falling clock edge and is sampled on the rising edge. The status flags follow a read-then-write-zero rule for clearing. Software must bring the port up in a fixed order:

1. Clear both enable bits.
2. Write the mode and bit-rate registers.
3. Wait for one bit period.
4. Write the final control value.

A byte that arrives while the previous byte is still unread raises an overrun flag. Reception then stops until software clears that flag.

Top module: `sync_serial_port`

## Requirements
- R1: The byte registers are at these offsets: mode 0, bit rate 1, control 2, transmit data 3, status 4, receive data 5. After reset, status reads 0x84 and the serial clock and data outputs are high. The other registers read 0.
- R2: Mode bit 7 set to 1 selects clocked synchronous operation. Mode bits 1:0 select a prescale of 4^k system clocks. Each half of a serial clock period lasts 4^k·2·(N+1) system clocks, where N is the bit-rate value.
- R3: Control bit 5 enables the transmitter and bit 4 enables the receiver. Control bit 1 selects the clock source: 0 selects the internal clock, which drives the serial clock pin with `sclk_oe`=1; 1 selects the peer's clock on `sclk_i`.
- R4: Writes to the mode and bit-rate registers are ignored while either enable bit is 1.
- R5: The transmitter starts when four conditions hold: it is enabled, synchronous mode is selected, the internal clock is selected, and status bit 7 (transmit-data-empty) is 0. The transmit data moves into the shifter and bit 7 returns to 1. Eight bits then go out least significant bit first, each placed on a falling edge.
- R6: When the eighth bit completes, one of two things happens:
  - If bit 7 is still 1, status bit 2 (transmit-end) is set and the clock idles high.
  - If bit 7 is 0, the next byte follows with no gap and bit 2 stays 0.
- R7: The receiver shifts data in on rising edges of its selected clock, least significant bit first. After eight bits it loads the receive data register and sets status bit 6 (receive-data-full).
- R8: If a byte completes while bit 6 is 1, status bit 5 (overrun) is set and the receive data register keeps its old byte. While bit 5 is 1, the receiver ignores the clock.
- R9: A status write clears a flag only when two conditions hold: the written bit is 0, and the flag was read as 1 since it was last set. Written 1s are ignored. Clearing bit 7 also clears bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sclk_i | input | 1 | Serial clock from peer |
| sclk_o | output | 1 | Serial clock driven by this node |
| sclk_oe | output | 1 | Serial clock output enable |
| rxd | input | 1 | Serial data in |
| txd | output | 1 | Serial data out |

## Verification
The assertions rely on two things about the inputs:
- Each bus access lasts one cycle.
- A peer clock on `sclk_i` holds each level for at least two system clocks, so that the two-stage synchronizer catches every edge.

The bench keeps to both. Every access is a single-cycle strobe driven at the falling clock edge. The peer clock always comes from a second instance whose shortest half period is two cycles. The bench also follows the required configuration order before it enables any node, so that no write is made to a locked register by mistake.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int SSP_ADDR_W = 3;
  localparam int SSP_BRR_W  = 8;
  localparam int SSP_CKS_W  = 2;
  localparam int SSP_PRE_W  = 6;

  localparam logic [SSP_ADDR_W-1:0] OFS_MODE = 3'd0;
  localparam logic [SSP_ADDR_W-1:0] OFS_RATE = 3'd1;
  localparam logic [SSP_ADDR_W-1:0] OFS_CTRL = 3'd2;
  localparam logic [SSP_ADDR_W-1:0] OFS_TXD  = 3'd3;
  localparam logic [SSP_ADDR_W-1:0] OFS_STAT = 3'd4;
  localparam logic [SSP_ADDR_W-1:0] OFS_RXD  = 3'd5;

  // flag vector index
  localparam int F_TXE  = 3;
  localparam int F_RXF  = 2;
  localparam int F_OVR  = 1;
  localparam int F_TEND = 0;

  // last count of the prescaler: 4^k - 1
  function automatic logic [SSP_PRE_W-1:0] pre_last(input logic [SSP_CKS_W-1:0] k);
    return (SSP_PRE_W'(1) << (2 * k)) - SSP_PRE_W'(1);
  endfunction

  // last count of the half-period counter: 2(N+1) - 1 = 2N + 1
  function automatic logic [SSP_BRR_W:0] half_last(input logic [SSP_BRR_W-1:0] n);
    return {n, 1'b1};
  endfunction
endpackage

// File: rtl/ssp_baud_gen.sv
module ssp_baud_gen
  import ssp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [SSP_CKS_W-1:0] cks,
  input  logic [SSP_BRR_W-1:0] rate,
  output logic                 half_tick
);
  logic [SSP_PRE_W-1:0] pre_q;
  logic [SSP_BRR_W:0]   cnt_q;
  logic                 pre_tick;

  assign pre_tick  = (pre_q == pre_last(cks));
  assign half_tick = pre_tick && (cnt_q == half_last(rate));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!run) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_tick ? '0 : pre_q + 1'b1;
      if (pre_tick) cnt_q <= half_tick ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: the generator is silent while no transfer runs
  a_r2_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> run);
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              txe,
  input  logic [DATA_W-1:0] tdr,
  input  logic              half_tick,
  output logic              busy,
  output logic              sclk,
  output logic              txd,
  output logic              load,
  output logic              done
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              hi_q;
  logic [CNT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              end_bit;

  assign end_bit = busy && half_tick && hi_q && (bit_q == LAST);
  assign load    = enable && !txe && (!busy || end_bit);
  assign done    = enable && txe && end_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk <= 1'b1; txd <= 1'b1;
      hi_q <= 1'b0; bit_q <= '0; sh_q <= '0;
    end else if (!enable) begin
      busy <= 1'b0; sclk <= 1'b1; txd <= 1'b1; hi_q <= 1'b0; bit_q <= '0;
    end else if (load) begin
      busy <= 1'b1; sclk <= 1'b0; hi_q <= 1'b0; bit_q <= '0;
      sh_q <= tdr;  txd  <= tdr[0];
    end else if (done) begin
      busy <= 1'b0; sclk <= 1'b1; txd <= 1'b1; hi_q <= 1'b0;
    end else if (busy && half_tick) begin
      if (!hi_q) begin
        sclk <= 1'b1; hi_q <= 1'b1;
      end else begin
        sclk  <= 1'b0; hi_q <= 1'b0;
        bit_q <= bit_q + 1'b1;
        sh_q  <= sh_q >> 1;
        txd   <= sh_q[1];
      end
    end
  end

  // R6: the clock rests high whenever no byte is in flight
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);
  // R5: data only changes together with a falling clock
  a_r5_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(txd)) |-> !sclk);
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sclk_raw,
  input  logic              rxd_raw,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] ck_sy, dt_sy;
  logic                   ck_prev, rise;
  logic [CNT_W-1:0]       bit_q;
  logic [DATA_W-1:0]      sh_q;

  assign rise = ck_sy[SYNC_STAGES-1] && !ck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sy <= '1; dt_sy <= '1; ck_prev <= 1'b1;
      bit_q <= '0; sh_q <= '0; done <= 1'b0; data <= '0;
    end else begin
      ck_sy   <= {ck_sy[SYNC_STAGES-2:0], sclk_raw};
      dt_sy   <= {dt_sy[SYNC_STAGES-2:0], rxd_raw};
      ck_prev <= ck_sy[SYNC_STAGES-1];
      done    <= 1'b0;
      if (!enable) begin
        bit_q <= '0;
      end else if (rise) begin
        sh_q  <= {dt_sy[SYNC_STAGES-1], sh_q[DATA_W-1:1]};
        bit_q <= bit_q + 1'b1;
        if (bit_q == LAST) begin
          done <= 1'b1;
          data <= {dt_sy[SYNC_STAGES-1], sh_q[DATA_W-1:1]};
        end
      end
    end
  end

  // R8: no byte can complete while the receiver is held off
  a_r8_no_done_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !done);
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [SSP_ADDR_W-1:0] bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic                  sclk_i,
  output logic                  sclk_o,
  output logic                  sclk_oe,
  input  logic                  rxd,
  output logic                  txd
);
  logic [7:0]        mode_q, rate_q, ctrl_q;
  logic [DATA_W-1:0] tdr_q, rdr_q;
  logic [3:0]        flags_q, seen_q, seen_nx, clr, set_ev;
  logic              sync_mode, use_int, tx_on, rx_on, cfg_lock;
  logic              wr_en, rd_stat, wr_stat;
  logic              half_tick, tx_busy, tx_sclk, tx_load, tx_done;
  logic              rx_done;
  logic [DATA_W-1:0] rx_data;

  assign sync_mode = mode_q[7];
  assign use_int   = !ctrl_q[1];
  assign tx_on     = ctrl_q[5] && sync_mode && use_int;
  assign rx_on     = ctrl_q[4] && sync_mode && !flags_q[F_OVR];
  assign cfg_lock  = ctrl_q[5] || ctrl_q[4];
  assign wr_en     = bus_sel && bus_wr;
  assign rd_stat   = bus_sel && !bus_wr && (bus_addr == OFS_STAT);
  assign wr_stat   = wr_en && (bus_addr == OFS_STAT);

  assign sclk_o  = tx_sclk;
  assign sclk_oe = use_int;

  ssp_baud_gen u_baud (
    .clk(clk), .rst_n(rst_n), .run(tx_busy),
    .cks(mode_q[SSP_CKS_W-1:0]), .rate(rate_q), .half_tick(half_tick));

  ssp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .enable(tx_on), .txe(flags_q[F_TXE]),
    .tdr(tdr_q), .half_tick(half_tick), .busy(tx_busy), .sclk(tx_sclk),
    .txd(txd), .load(tx_load), .done(tx_done));

  ssp_rx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(rx_on),
    .sclk_raw(use_int ? tx_sclk : sclk_i), .rxd_raw(rxd),
    .done(rx_done), .data(rx_data));

  // a flag clears only if written 0 after being seen as 1
  assign clr[F_TXE]  = wr_stat && !bus_wdata[7] && seen_q[F_TXE];
  assign clr[F_RXF]  = wr_stat && !bus_wdata[6] && seen_q[F_RXF];
  assign clr[F_OVR]  = wr_stat && !bus_wdata[5] && seen_q[F_OVR];
  assign clr[F_TEND] = wr_stat && !bus_wdata[2] && seen_q[F_TEND];
  assign set_ev = {tx_load, rx_done && !flags_q[F_RXF],
                   rx_done && flags_q[F_RXF], tx_done};

  always_comb begin
    seen_nx = seen_q;
    if (rd_stat) seen_nx = seen_nx | flags_q;
    seen_nx = seen_nx & ~(set_ev | clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; rate_q <= '0; ctrl_q <= '0; tdr_q <= '0; rdr_q <= '0;
      flags_q <= 4'b1001; seen_q <= '0;
    end else begin
      if (wr_en && !cfg_lock && bus_addr == OFS_MODE) mode_q <= bus_wdata;
      if (wr_en && !cfg_lock && bus_addr == OFS_RATE) rate_q <= bus_wdata;
      if (wr_en && bus_addr == OFS_CTRL) ctrl_q <= bus_wdata;
      if (wr_en && bus_addr == OFS_TXD)  tdr_q  <= bus_wdata[DATA_W-1:0];
      seen_q <= seen_nx;
      if (tx_load) flags_q[F_TXE] <= 1'b1;
      else if (clr[F_TXE]) flags_q[F_TXE] <= 1'b0;
      if (tx_done) flags_q[F_TEND] <= 1'b1;
      else if (clr[F_TEND] || clr[F_TXE]) flags_q[F_TEND] <= 1'b0;
      if (set_ev[F_RXF]) begin
        flags_q[F_RXF] <= 1'b1;
        rdr_q <= rx_data;
      end else if (clr[F_RXF]) flags_q[F_RXF] <= 1'b0;
      if (set_ev[F_OVR]) flags_q[F_OVR] <= 1'b1;
      else if (clr[F_OVR]) flags_q[F_OVR] <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MODE: bus_rdata = mode_q;
      OFS_RATE: bus_rdata = rate_q;
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_TXD:  bus_rdata = 8'(tdr_q);
      OFS_STAT: bus_rdata = {flags_q[F_TXE], flags_q[F_RXF], flags_q[F_OVR],
                             2'b00, flags_q[F_TEND], 2'b00};
      OFS_RXD:  bus_rdata = 8'(rdr_q);
      default:  bus_rdata = '0;
    endcase
  end

  // R4: configuration is frozen while a direction is enabled
  a_r4_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> ($stable(mode_q) && $stable(rate_q)));
  // R5: moving a byte into the shifter frees the data register
  a_r5_load_sets_txe: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> flags_q[F_TXE]);
  // R7: a completed byte with room lands in the data register
  a_r7_byte_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !flags_q[F_RXF]) |=> (flags_q[F_RXF] && rdr_q == $past(rx_data)));
  // R8: overrun keeps the old byte and raises the flag
  a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && flags_q[F_RXF]) |=> (flags_q[F_OVR] && $stable(rdr_q)));
  // R9: a status write never raises a flag
  a_r9_write_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && set_ev == 4'b0) |=> ((flags_q & ~$past(flags_q)) == 4'b0));
endmodule

// File: tb/test_sync_serial_port.sv
`timescale 1ns/1ps
module test_sync_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_sel = 0, m_wr = 0, s_sel = 0, s_wr = 0;
  logic [2:0] m_addr = '0, s_addr = '0;
  logic [7:0] m_wdata = '0, s_wdata = '0, m_rdata, s_rdata;
  logic m_sclk_o, m_sclk_oe, m_txd, s_sclk_o, s_sclk_oe, s_txd;

  sync_serial_port i_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(m_sel), .bus_wr(m_wr),
    .bus_addr(m_addr), .bus_wdata(m_wdata), .bus_rdata(m_rdata),
    .sclk_i(s_sclk_o), .sclk_o(m_sclk_o), .sclk_oe(m_sclk_oe),
    .rxd(s_txd), .txd(m_txd));

  sync_serial_port i_peer (
    .clk(clk), .rst_n(rst_n), .bus_sel(s_sel), .bus_wr(s_wr),
    .bus_addr(s_addr), .bus_wdata(s_wdata), .bus_rdata(s_rdata),
    .sclk_i(m_sclk_o), .sclk_o(s_sclk_o), .sclk_oe(s_sclk_oe),
    .rxd(m_txd), .txd(s_txd));

  int n_chk = 0, n_err = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // independent restatement of the half period
  function automatic int half_cyc(input int k, input int n);
    return (4 ** k) * 2 * (n + 1);
  endfunction

  // monitor of the master's serial clock, sampled away from the edge
  logic prev_ck = 1'b1;
  int low_run = 0, high_run = 0, last_low = 0, falls = 0, gap9 = 0;
  logic [7:0] cap = '0;
  always @(negedge clk) begin
    if (!m_sclk_o) low_run++; else high_run++;
    if (m_sclk_o && !prev_ck) begin
      last_low = low_run; low_run = 0;
      cap = {m_txd, cap[7:1]};
    end
    if (!m_sclk_o && prev_ck) begin
      falls++;
      if (falls == 9) gap9 = high_run;
      high_run = 0;
    end
    prev_ck = m_sclk_o;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wr(input bit node, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    if (node) begin s_sel = 1; s_wr = 1; s_addr = a; s_wdata = d; end
    else      begin m_sel = 1; m_wr = 1; m_addr = a; m_wdata = d; end
    @(negedge clk);
    s_sel = 0; s_wr = 0; m_sel = 0; m_wr = 0;
  endtask

  task automatic rd(input bit node, input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    if (node) begin s_sel = 1; s_wr = 0; s_addr = a; end
    else      begin m_sel = 1; m_wr = 0; m_addr = a; end
    #1;
    d = node ? s_rdata : m_rdata;
    @(negedge clk);
    s_sel = 0; m_sel = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // disable, configure, wait a bit period, enable
  task automatic cfg(input bit node, input int k, input int n, input logic [7:0] ctl);
    wr(node, 3'd2, 8'h00);
    wr(node, 3'd0, 8'h80 | 8'(k));
    wr(node, 3'd1, 8'(n));
    repeat (2 * half_cyc(k, n)) @(negedge clk);
    wr(node, 3'd2, ctl);
  endtask

  task automatic poll(input bit node, input logic [7:0] mask, output logic [7:0] st);
    for (int i = 0; i < 3000; i++) begin
      rd(node, 3'd4, st);
      if ((st & mask) != 0) break;
    end
  endtask

  task automatic send(input logic [7:0] d);
    logic [7:0] st;
    rd(0, 3'd4, st);
    wr(0, 3'd3, d);
    wr(0, 3'd0 + 3'd4, 8'h00);
    poll(0, 8'h04, st);
  endtask

  localparam logic [17:0] VEC [0:3] = '{
    {2'd0, 8'd1, 8'hA5},
    {2'd0, 8'd3, 8'h3C},
    {2'd1, 8'd0, 8'h01},
    {2'd0, 8'd0, 8'h80}
  };

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset state
    rd(0, 3'd0, v); check("R1 mode reset", v, 8'h00);
    rd(0, 3'd1, v); check("R1 rate reset", v, 8'h00);
    rd(0, 3'd2, v); check("R1 ctrl reset", v, 8'h00);
    rd(0, 3'd3, v); check("R1 tdr reset", v, 8'h00);
    rd(0, 3'd5, v); check("R1 rdr reset", v, 8'h00);
    check("R1 sclk idle", m_sclk_o, 1);
    check("R1 txd idle", m_txd, 1);
    // R9 write 0 with no prior read: no effect
    wr(0, 3'd4, 8'h00);
    rd(0, 3'd4, v); check("R9 clear needs read", v, 8'h84);
    wr(0, 3'd4, 8'hFF);
    rd(0, 3'd4, v); check("R9 ones ignored", v, 8'h84);
    wr(0, 3'd4, 8'h00);
    rd(0, 3'd4, v); check("R9 clear after read", v, 8'h00);
    do_reset();
    rd(1, 3'd4, v); check("R1 status reset", v, 8'h84);

    // vector walk: R2, R5, R6, R7
    for (int i = 0; i < 4; i++) begin
      int k, n;
      logic [7:0] d;
      k = int'(VEC[i][17:16]); n = int'(VEC[i][15:8]); d = VEC[i][7:0];
      cfg(0, k, n, 8'h20);
      cfg(1, k, n, 8'h12);
      send(d);
      check("R5 lsb-first bits", cap, d);
      check("R2 low half period", last_low, half_cyc(k, n));
      rd(0, 3'd4, v); check("R6 tend set", v & 8'h84, 8'h84);
      check("R6 sclk idles high", m_sclk_o, 1);
      poll(1, 8'h40, v);
      rd(1, 3'd5, v); check("R7 byte received", v, d);
      wr(1, 3'd4, 8'h00);
      rd(1, 3'd4, v); check("R9 flags cleared", v, 8'h00);
    end
    check("R3 master drives clock", m_sclk_oe, 1);
    check("R3 peer takes clock", s_sclk_oe, 0);

    // R4 locked configuration
    wr(0, 3'd0, 8'h83);
    wr(0, 3'd1, 8'h55);
    rd(0, 3'd0, v); check("R4 mode locked", v, 8'h80);
    rd(0, 3'd1, v); check("R4 rate locked", v, 8'h00);

    // R8 overrun
    cfg(0, 0, 1, 8'h20);
    cfg(1, 0, 1, 8'h12);
    send(8'h11);
    send(8'h22);
    repeat (8) @(negedge clk);
    rd(1, 3'd4, v); check("R8 overrun flags", v, 8'h60);
    rd(1, 3'd5, v); check("R8 old byte kept", v, 8'h11);
    send(8'h33);
    repeat (8) @(negedge clk);
    rd(1, 3'd5, v); check("R8 held while overrun", v, 8'h11);
    rd(1, 3'd4, v);
    wr(1, 3'd4, 8'h00);
    rd(1, 3'd4, v); check("R9 overrun cleared", v, 8'h00);
    send(8'h44);
    poll(1, 8'h40, v);
    rd(1, 3'd5, v); check("R8 recovers", v, 8'h44);

    // R6 back-to-back bytes
    cfg(0, 0, 3, 8'h20);
    rd(0, 3'd4, v);
    wr(0, 3'd3, 8'h5A);
    falls = 0;
    wr(0, 3'd4, 8'h00);
    poll(0, 8'h80, v);
    check("R6 no tend mid-stream", v & 8'h04, 8'h00);
    wr(0, 3'd3, 8'hC3);
    wr(0, 3'd4, 8'h00);
    poll(0, 8'h04, v);
    check("R6 sixteen falls", falls, 16);
    check("R6 no gap", gap9, half_cyc(0, 3));
    check("R5 second byte", cap, 8'hC3);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule